// File: doc/BRIEF.md
# Serial Frequency and Phase Word Loader

This block receives 16-bit command words on a three-wire serial port and routes each word into one of five holding registers. The registers are a 14-bit control register, two 28-bit frequency words and two 12-bit phase words. It sits in front of a numerically controlled oscillator and gives it stable tuning words. The serial clock, frame strobe and data line are oversampled by the system clock `clk`. Bits are taken on each falling edge of the serial clock while the active-low frame strobe is held low. A word is acted on only once its sixteenth bit has arrived.

The two top bits of a word pick its destination. A frequency word is wider than one payload, so it is loaded 14 bits at a time, and control bit 13 picks how. When that bit is set, two writes to the same frequency register form one value. The first write is the low half and is held in a staging register. The second write is the high half, and both halves reach the output together. When that bit is clear, each write replaces one half in place, and control bit 12 names that half.

Each frequency register has its own two-state sequencer. The states are HALF_LO (the next write is the low half) and HALF_HI (a low half is staged and the next write commits). Transitions: HALF_LO to HALF_HI on a full-mode write; HALF_HI to HALF_LO on a full-mode write (commit); any state to HALF_LO on a control write. The serial front end has three states: SH_IDLE (strobe high), SH_SHIFT (collecting bits) and SH_HOLD (word taken, surplus bits ignored). Transitions: SH_IDLE to SH_SHIFT when the strobe falls; SH_SHIFT to SH_HOLD on the sixteenth edge; SH_SHIFT to SH_IDLE when the strobe rises early (the frame is dropped); SH_HOLD to SH_IDLE when the strobe rises.

Top module: `dds_word_loader`

## Requirements
- R1: Bits are shifted in MSB first on falling edges of `sclk` while `fsync_n` is low. The register outputs show the result of a word at the fourth rising `clk` edge after the `sclk` fall that carried bit 0.
- R2: A frame in which `fsync_n` rises before the sixteenth falling edge changes no output.
- R3: Word bits 15:14 select the destination: 00 control, 01 frequency 0, 10 frequency 1, 11 phase. A control write sets `ctrl_bits` to word bits 13:0.
- R4: In a phase write, bit 13 picks the register (0 = phase 0, 1 = phase 1), bits 11:0 become its value, and bit 12 has no effect.
- R5: When `ctrl_bits[13]` is 1, the first write to a frequency register leaves its output unchanged. The second write sets the output to {second payload, first payload} in one step.
- R6: When `ctrl_bits[13]` is 0, a frequency write replaces bits 27:14 if `ctrl_bits[12]` is 1, or bits 13:0 if it is 0, and leaves the other half unchanged.
- R7: The two frequency registers track their write pairs independently, so interleaved pairs commit correctly.
- R8: A control write makes the next full-mode write to either frequency register a low half, even if a low half was pending.
- R9: Falling edges after the sixteenth in the same frame are ignored.
- R10: If the sixteenth falling edge and the rise of `fsync_n` are seen in the same cycle, the word is accepted.
- R11: After reset all register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| fsync_n | input | 1 | Active-low frame strobe |
| sdata | input | 1 | Serial data, MSB first |
| ctrl_bits | output | 14 | Control register contents |
| freq0_word | output | 28 | Frequency word 0 |
| freq1_word | output | 28 | Frequency word 1 |
| phase0_word | output | 12 | Phase word 0 |
| phase1_word | output | 12 | Phase word 1 |

## Verification
The end of a frame and the capture of its sixteenth bit can fall in the same clock cycle. If the design gave the frame end priority, it would silently drop a complete word. The bench provokes this by raising `fsync_n` in the same instant that it drives the last `sclk` fall. The two events then pass through equal-depth synchronisers and meet in one cycle. The behavioural model expects that word to be committed, and every output is compared with the model on every clock. Any loss or late arrival of the word shows up as a mismatch.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
    typedef enum logic [1:0] {
        DST_CTRL  = 2'b00,
        DST_FREQ0 = 2'b01,
        DST_FREQ1 = 2'b10,
        DST_PHASE = 2'b11
    } dest_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'b00,
        SH_SHIFT = 2'b01,
        SH_HOLD  = 2'b10
    } shift_state_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_state_e;
endpackage

// File: rtl/dwl_shifter.sv
module dwl_shifter
    import dwl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdata,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_q
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [2:0]       sclk_sync;
    logic [1:0]       fs_sync;
    logic [1:0]       sd_sync;
    logic             sclk_fall;
    logic             fs_high;
    logic             last_bit;
    logic [CNT_W-1:0] cnt_q;
    shift_state_e     state_q, state_d;
    logic             shift_en;
    logic             take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sync <= 3'b111;
            fs_sync   <= 2'b11;
            sd_sync   <= 2'b00;
        end else begin
            sclk_sync <= {sclk_sync[1:0], sclk};
            fs_sync   <= {fs_sync[0], fsync_n};
            sd_sync   <= {sd_sync[0], sdata};
        end
    end

    assign sclk_fall = sclk_sync[2] & ~sclk_sync[1];
    assign fs_high   = fs_sync[1];
    assign last_bit  = (cnt_q == CNT_W'(WORD_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        shift_en = 1'b0;
        take     = 1'b0;
        unique case (state_q)
            SH_IDLE: begin
                if (!fs_high) state_d = SH_SHIFT;
            end
            SH_SHIFT: begin
                if (sclk_fall && last_bit) begin
                    shift_en = 1'b1;
                    take     = 1'b1;
                    state_d  = SH_HOLD;
                end else if (fs_high) begin
                    state_d = SH_IDLE;
                end else if (sclk_fall) begin
                    shift_en = 1'b1;
                end
            end
            SH_HOLD: begin
                if (fs_high) state_d = SH_IDLE;
            end
            default: state_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            word_q     <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= take;
            if (state_q != SH_SHIFT) cnt_q <= '0;
            else if (shift_en)       cnt_q <= cnt_q + 1'b1;
            if (shift_en) word_q <= {word_q[WORD_W-2:0], sd_sync[1]};
        end
    end
endmodule

// File: rtl/dwl_freq_slot.sv
module dwl_freq_slot
    import dwl_pkg::*;
#(
    parameter int HALF_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                clr,
    input  logic                full_mode,
    input  logic                hi_sel,
    input  logic [HALF_W-1:0]   din,
    output logic [2*HALF_W-1:0] value
);
    half_state_e       state_q, state_d;
    logic              stage_ld;
    logic              commit;
    logic [HALF_W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HALF_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        stage_ld = 1'b0;
        commit   = 1'b0;
        if (clr) begin
            state_d = HALF_LO;
        end else if (wr && full_mode) begin
            unique case (state_q)
                HALF_LO: begin
                    stage_ld = 1'b1;
                    state_d  = HALF_HI;
                end
                HALF_HI: begin
                    commit  = 1'b1;
                    state_d = HALF_LO;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            value   <= '0;
        end else begin
            if (stage_ld) stage_q <= din;
            if (commit) begin
                value <= {din, stage_q};
            end else if (wr && !full_mode) begin
                if (hi_sel) value[2*HALF_W-1:HALF_W] <= din;
                else        value[HALF_W-1:0]        <= din;
            end
        end
    end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dwl_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int FREQ_W  = 28,
    parameter int PHASE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               fsync_n,
    input  logic               sdata,
    output logic [WORD_W-3:0]  ctrl_bits,
    output logic [FREQ_W-1:0]  freq0_word,
    output logic [FREQ_W-1:0]  freq1_word,
    output logic [PHASE_W-1:0] phase0_word,
    output logic [PHASE_W-1:0] phase1_word
);
    localparam int PAY_W  = WORD_W - 2;
    localparam int HALF_W = FREQ_W / 2;
    localparam int FULL_B = PAY_W - 1;
    localparam int HLB_B  = PAY_W - 2;
    localparam int PSEL_B = PAY_W - 1;

    logic              word_valid;
    logic [WORD_W-1:0] word_q;
    dest_e             dest;
    logic              ctrl_wr;
    logic [FREQ_W-1:0] fword [2];

    dwl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .fsync_n   (fsync_n),
        .sdata     (sdata),
        .word_valid(word_valid),
        .word_q    (word_q)
    );

    assign dest    = dest_e'(word_q[WORD_W-1 -: 2]);
    assign ctrl_wr = word_valid && (dest == DST_CTRL);

    for (genvar g = 0; g < 2; g++) begin : g_freq
        dwl_freq_slot #(.HALF_W(HALF_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (word_valid && (word_q[WORD_W-1 -: 2] == 2'(g + 1))),
            .clr      (ctrl_wr),
            .full_mode(ctrl_bits[FULL_B]),
            .hi_sel   (ctrl_bits[HLB_B]),
            .din      (word_q[HALF_W-1:0]),
            .value    (fword[g])
        );
    end

    assign freq0_word = fword[0];
    assign freq1_word = fword[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_bits   <= '0;
            phase0_word <= '0;
            phase1_word <= '0;
        end else if (word_valid) begin
            unique case (dest)
                DST_CTRL:  ctrl_bits <= word_q[PAY_W-1:0];
                DST_PHASE: begin
                    if (word_q[PSEL_B]) phase1_word <= word_q[PHASE_W-1:0];
                    else                phase0_word <= word_q[PHASE_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dwl_checker.sv
module dwl_checker #(
    parameter int WORD_W  = 16,
    parameter int FREQ_W  = 28,
    parameter int PHASE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               word_valid,
    input logic [WORD_W-1:0]  word_q,
    input logic [WORD_W-3:0]  ctrl_bits,
    input logic [FREQ_W-1:0]  freq0_word,
    input logic [FREQ_W-1:0]  freq1_word,
    input logic [PHASE_W-1:0] phase0_word,
    input logic [PHASE_W-1:0] phase1_word
);
    localparam int HW = FREQ_W / 2;

    assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_q[WORD_W-1 -: 2] == 2'b00) |=> ctrl_bits == $past(word_q[WORD_W-3:0]));

    assert_freq1_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq1_word) |-> $past(word_valid && word_q[WORD_W-1 -: 2] == 2'b10));

    assert_phase0_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase0_word) |-> $past(word_valid && word_q[WORD_W-1 -: 2] == 2'b11 && !word_q[WORD_W-3]));

    assert_full_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(freq0_word) && $past(ctrl_bits[WORD_W-3])) |-> freq0_word[FREQ_W-1:HW] == $past(word_q[HW-1:0]));

    assert_split_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(freq0_word) && !$past(ctrl_bits[WORD_W-3]) && $past(ctrl_bits[WORD_W-4])) |-> freq0_word[HW-1:0] == $past(freq0_word[HW-1:0]));

    assert_phase1_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase1_word) |-> $past(word_valid && word_q[WORD_W-1 -: 2] == 2'b11 && word_q[WORD_W-3]));
endmodule

bind dds_word_loader dwl_checker #(
    .WORD_W (WORD_W),
    .FREQ_W (FREQ_W),
    .PHASE_W(PHASE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_q     (word_q),
    .ctrl_bits  (ctrl_bits),
    .freq0_word (freq0_word),
    .freq1_word (freq1_word),
    .phase0_word(phase0_word),
    .phase1_word(phase1_word)
);

// File: tb/test_dds_word_loader.sv
module test_dds_word_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic fsync_n = 1'b1;
    logic sdata = 1'b0;
    logic [13:0] ctrl_bits;
    logic [27:0] freq0_word, freq1_word;
    logic [11:0] phase0_word, phase1_word;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 0;
    bit done = 0;
    string cur_req = "R11";

    logic [13:0] m_ctrl = '0;
    logic [27:0] m_freq [2] = '{default: '0};
    logic [11:0] m_phase [2] = '{default: '0};
    logic [13:0] m_stage [2] = '{default: '0};
    bit          m_tog [2] = '{default: 0};
    int          pend_cnt = 0;
    logic [15:0] pend_word = '0;

    always #2 clk = ~clk;

    dds_word_loader i_dds_word_loader (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdata(sdata),
        .ctrl_bits(ctrl_bits), .freq0_word(freq0_word), .freq1_word(freq1_word),
        .phase0_word(phase0_word), .phase1_word(phase1_word)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model_apply(input logic [15:0] w);
        int i;
        case (w[15:14])
            2'b00: begin m_ctrl = w[13:0]; m_tog[0] = 0; m_tog[1] = 0; end
            2'b11: m_phase[w[13]] = w[11:0];
            default: begin
                i = (w[15:14] == 2'b01) ? 0 : 1;
                if (m_ctrl[13]) begin
                    if (!m_tog[i]) begin m_stage[i] = w[13:0]; m_tog[i] = 1; end
                    else begin m_freq[i] = {w[13:0], m_stage[i]}; m_tog[i] = 0; end
                end else if (m_ctrl[12]) m_freq[i][27:14] = w[13:0];
                else m_freq[i][13:0] = w[13:0];
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (pend_cnt > 0) begin
            if (pend_cnt == 1) model_apply(pend_word);
            pend_cnt--;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk(cur_req, "ctrl", 32'(ctrl_bits), 32'(m_ctrl));
            chk(cur_req, "freq0", 32'(freq0_word), 32'(m_freq[0]));
            chk(cur_req, "freq1", 32'(freq1_word), 32'(m_freq[1]));
            chk(cur_req, "phase0", 32'(phase0_word), 32'(m_phase[0]));
            chk(cur_req, "phase1", 32'(phase1_word), 32'(m_phase[1]));
        end
    end

    // n bits are clocked; bits past 16 are ones. late_rise raises fsync_n with the 16th fall.
    task automatic frame(input logic [15:0] w, input int n, input bit late_rise);
        @(negedge clk) fsync_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdata = (i < 16) ? w[15 - i] : 1'b1;
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            if (i == 15) begin
                pend_word = w;
                pend_cnt = 4;
                if (late_rise) fsync_n = 1'b1;
            end
            repeat (3) @(negedge clk);
        end
        sclk = 1'b1;
        fsync_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        frame(w, 16, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values
        chk("R11", "ctrl", 32'(ctrl_bits), 0);
        chk("R11", "freq0", 32'(freq0_word), 0);
        chk("R11", "freq1", 32'(freq1_word), 0);
        chk("R11", "phase0", 32'(phase0_word), 0);
        chk("R11", "phase1", 32'(phase1_word), 0);
        cmp_en = 1;

        cur_req = "R5";
        send(16'h2000); send(16'h4000); send(16'h403F);
        chk("R5", "freq0 28-bit load", 32'(freq0_word), 32'h00FC000);
        chk("R3", "ctrl full mode", 32'(ctrl_bits), 32'h2000);

        cur_req = "R6";
        send(16'h0000); send(16'hBFFF);
        chk("R6", "freq1 low half", 32'(freq1_word), 32'h0003FFF);
        send(16'h1000); send(16'h40FF);
        chk("R6", "freq0 high half", 32'(freq0_word), 32'h03FC000);

        cur_req = "R4";
        send(16'hC123); send(16'hF456);
        chk("R4", "phase0", 32'(phase0_word), 32'h123);
        chk("R4", "phase1 bit12 set", 32'(phase1_word), 32'h456);
        send(16'hE789);
        chk("R4", "phase1", 32'(phase1_word), 32'h789);

        cur_req = "R7";
        send(16'h2000); send(16'h4111); send(16'h8222); send(16'h4333); send(16'h8444);
        chk("R7", "freq0 interleaved", 32'(freq0_word), {4'h0, 14'h0333, 14'h0111});
        chk("R7", "freq1 interleaved", 32'(freq1_word), {4'h0, 14'h0444, 14'h0222});

        cur_req = "R8";
        send(16'h4AAA); send(16'h2000); send(16'h4555);
        chk("R8", "freq0 after staged low", 32'(freq0_word), {4'h0, 14'h0333, 14'h0111});
        send(16'h4666);
        chk("R8", "freq0 pair after ctrl", 32'(freq0_word), {4'h0, 14'h0666, 14'h0555});

        cur_req = "R2";
        frame(16'h0000, 10, 1'b0);
        frame(16'hC7FF, 15, 1'b0);
        chk("R2", "ctrl after short frames", 32'(ctrl_bits), 32'h2000);
        chk("R2", "phase0 after short frame", 32'(phase0_word), 32'h123);

        cur_req = "R9";
        frame(16'hC0AB, 20, 1'b0);
        chk("R9", "phase0 with surplus bits", 32'(phase0_word), 32'h0AB);

        cur_req = "R10";
        frame(16'hE0CD, 16, 1'b1);
        chk("R10", "phase1 at frame end", 32'(phase1_word), 32'h0CD);

        cur_req = "R1";
        send(16'h3ABC);
        chk("R1", "ctrl msb-first", 32'(ctrl_bits), 32'h3ABC);

        cmp_en = 0;
        done = 1;
        finish_run();
    end
endmodule